// File: doc/BRIEF.md
# Legacy Memory Region Router

This block decides where each memory cycle seen by a host memory controller should go. A cycle can be claimed by main memory (DRAM), passed on to the I/O hub (HUB), or dropped (IGNORE). The decision depends on three things: the cycle's address, whether it is a read or a write, and whether the host or an I/O-side agent started it. Configuration software sets up the routing through a byte-wide port at offsets 58h to 5Fh.

There are two kinds of routing state.

- **Shadow segments.** Thirteen segments in the region from C0000h to FFFFFh each carry a read-enable bit and a write-enable bit. The two bits are used separately for each direction, so a segment can be read-only, write-only, read/write or disabled.
- **Fixed hole.** A single hole from 15 MB up to, but not including, 16 MB can be switched on. While it is on, host cycles in that range go to the hub and I/O-side cycles there are dropped. The DRAM behind the hole cannot be reached and is not remapped.

A request is offered with a one-cycle strobe, `req_valid`. Its decision appears on `out_route` with `out_valid` high exactly one clock later. The block accepts a request on every cycle and has no ready signal. The consumer cannot apply back-pressure: every result is valid for one cycle only and must be taken in that cycle.

Top module: `legacy_region_router`

## Requirements
- R1: After reset every register at offsets 58h–5Fh reads 00h, `out_valid` is low, and with the hole off and all enable bits clear, cycles outside C0000h–FFFFFh go to DRAM.
- R2: Offset 58h stores only bit 7, the hole enable. Bits 6:0 always read as zero.
- R3: In offsets 5Ah–5Fh each nibble stores bits 1:0 and reads bits 3:2 as zero. At 59h only the upper nibble is stored, and the lower nibble reads as zero.
- R4: A read that falls in a segment goes to DRAM when that segment's read-enable bit (nibble bit 0) is 1, and to HUB when it is 0. The segment map is as follows:
  - 59h upper nibble covers F0000h–FFFFFh.
  - Offset 5Ah+k, lower nibble, covers the 16 KB block at C0000h+2k·4000h.
  - Offset 5Ah+k, upper nibble, covers the 16 KB block at C0000h+(2k+1)·4000h.
- R5: A write that falls in a segment goes to DRAM when that segment's write-enable bit (nibble bit 1) is 1, and to HUB when it is 0. The read-enable bit has no effect on writes.
- R6: With the hole on, a host cycle (`req_io`=0) at an address from F00000h to FFFFFFh goes to HUB.
- R7: With the hole on, an I/O-side cycle (`req_io`=1) in the same range is IGNORE.
- R8: With the hole off, addresses from F00000h to FFFFFFh go to DRAM. Addresses EFFFFFh and 1000000h go to DRAM whether the hole is on or off.
- R9: Addresses below C0000h (including A0000h–BFFFFh) and above FFFFFh that are not in an enabled hole go to DRAM.
- R10: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. `out_route` then holds one of three codes: 0 = DRAM, 1 = HUB, 2 = IGNORE.
- R11: Writes to configuration offsets outside 58h–5Fh change no register, and reads there return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_addr | input | 32 | Cycle address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O-side initiator, 0 = host |
| out_valid | output | 1 | Decision valid (one cycle after `req_valid`) |
| out_route | output | 2 | 0 = DRAM, 1 = HUB, 2 = IGNORE |

## Verification
Directed sweeps run all four enable combinations on every one of the thirteen segments. Each combination is tried with a read and with a write, which shows whether a segment is indexed wrongly and whether the read and write bits have been swapped. Hole tests cover both initiator types and both edges of the hole, with the hole on and off; these separate HUB from IGNORE and catch an off-by-one at the range limits. Seeded random configuration writes are mixed with addresses drawn from the segments, the unclaimed A0000h–BFFFFh window, the hole and the full address space, and each result is compared against a bench model.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
  typedef enum logic [1:0] {
    RT_DRAM   = 2'd0,
    RT_HUB    = 2'd1,
    RT_IGNORE = 2'd2
  } route_t;

  typedef enum logic {
    SRC_HOST = 1'b0,
    SRC_IO   = 1'b1
  } src_t;

  localparam int ATTR_W   = 2;   // bit0 read enable, bit1 write enable
  localparam int NSMALL   = 12;  // 16 KB segments
  localparam int NSEG     = NSMALL + 1;
  localparam int NPAIR    = NSMALL / 2;
  localparam int NREG     = NPAIR + 2;
endpackage

// File: rtl/lrr_cfg_regs.sv
module lrr_cfg_regs
  import lrr_pkg::*;
#(
  parameter int             CFG_AW   = 8,
  parameter logic [7:0]     BASE_OFS = 8'h58
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  output logic [7:0]                   cfg_rdata,
  output logic                         hole_en,
  output logic [NSEG-1:0][ATTR_W-1:0]  attr
);
  localparam logic [CFG_AW-1:0] BASE = CFG_AW'(BASE_OFS);

  logic [CFG_AW-1:0]            offs;
  logic                         in_range;
  logic                         hole_q;
  logic [NSEG-1:0][ATTR_W-1:0]  attr_q;

  assign offs     = cfg_addr - BASE;
  assign in_range = (cfg_addr >= BASE) && (offs < CFG_AW'(NREG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hole_q <= 1'b0;
      attr_q <= '0;
    end else if (cfg_wr && in_range) begin
      if (offs == CFG_AW'(0)) hole_q <= cfg_wdata[7];
      if (offs == CFG_AW'(1)) attr_q[NSMALL] <= cfg_wdata[5:4];
      for (int k = 0; k < NPAIR; k++) begin
        if (offs == CFG_AW'(k + 2)) begin
          attr_q[2*k]   <= cfg_wdata[1:0];
          attr_q[2*k+1] <= cfg_wdata[5:4];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (in_range) begin
      if (offs == CFG_AW'(0)) cfg_rdata = {hole_q, 7'b0};
      if (offs == CFG_AW'(1)) cfg_rdata = {2'b00, attr_q[NSMALL], 4'h0};
      for (int k = 0; k < NPAIR; k++) begin
        if (offs == CFG_AW'(k + 2))
          cfg_rdata = {2'b00, attr_q[2*k+1], 2'b00, attr_q[2*k]};
      end
    end
  end

  assign hole_en = hole_q;
  assign attr    = attr_q;

  // R2: a write to the hole register lands its bit 7 in the enable
  p_hole_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == BASE) |=> (hole_en == $past(cfg_wdata[7])));

  // R11: stray offsets leave every register untouched
  p_stray_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !in_range) |=> ($stable(hole_en) && $stable(attr)));
endmodule

// File: rtl/lrr_seg_lookup.sv
module lrr_seg_lookup
  import lrr_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [31:0]     SEG_BASE   = 32'h000C_0000,
  parameter int              SMALL_LOG2 = 14,
  parameter logic [31:0]     TOP_BASE   = 32'h000F_0000,
  parameter int              TOP_LOG2   = 16,
  parameter logic [31:0]     HOLE_BASE  = 32'h00F0_0000,
  parameter int              HOLE_LOG2  = 20
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NSEG-1:0]    seg_hit,
  output logic               hole_hit
);
  localparam int SW = ADDR_W - SMALL_LOG2;
  localparam int TW = ADDR_W - TOP_LOG2;
  localparam int HW = ADDR_W - HOLE_LOG2;
  localparam logic [SW-1:0] SMALL_TAG0 = SW'(SEG_BASE >> SMALL_LOG2);
  localparam logic [TW-1:0] TOP_TAG    = TW'(TOP_BASE >> TOP_LOG2);
  localparam logic [HW-1:0] HOLE_TAG   = HW'(HOLE_BASE >> HOLE_LOG2);

  for (genvar i = 0; i < NSMALL; i++) begin : g_small
    assign seg_hit[i] = (addr[ADDR_W-1:SMALL_LOG2] == SMALL_TAG0 + SW'(i));
  end
  assign seg_hit[NSMALL] = (addr[ADDR_W-1:TOP_LOG2] == TOP_TAG);
  assign hole_hit        = (addr[ADDR_W-1:HOLE_LOG2] == HOLE_TAG);

  // R4: an address selects at most one segment and never both a segment and the hole
  always_comb begin
    p_seg_onehot_r4: assert ($onehot0(seg_hit));
    p_seg_hole_apart_r8: assert (!(hole_hit && (|seg_hit)));
  end
endmodule

// File: rtl/lrr_route_decide.sv
module lrr_route_decide
  import lrr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_wr,
  input  src_t                         req_src,
  input  logic [NSEG-1:0]              seg_hit,
  input  logic                         hole_hit,
  input  logic                         hole_en,
  input  logic [NSEG-1:0][ATTR_W-1:0]  attr,
  output logic                         out_valid,
  output route_t                       out_route
);
  logic [ATTR_W-1:0] sel_attr;
  logic              dir_en;
  route_t            route_d;

  always_comb begin
    sel_attr = '0;
    for (int i = 0; i < NSEG; i++)
      if (seg_hit[i]) sel_attr = sel_attr | attr[i];
  end

  assign dir_en = req_wr ? sel_attr[1] : sel_attr[0];

  always_comb begin
    route_d = RT_DRAM;
    if (hole_en && hole_hit)
      route_d = (req_src == SRC_IO) ? RT_IGNORE : RT_HUB;
    else if (|seg_hit)
      route_d = dir_en ? RT_DRAM : RT_HUB;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_route <= RT_DRAM;
    end else begin
      out_valid <= req_valid;
      if (req_valid) out_route <= route_d;
    end
  end

  // R7: I/O-side cycles into an enabled hole are dropped
  p_io_hole_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hole_en && hole_hit && req_src == SRC_IO) |=> (out_route == RT_IGNORE));

  // R6: host cycles into an enabled hole go to the hub
  p_host_hole_hub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hole_en && hole_hit && req_src == SRC_HOST) |=> (out_route == RT_HUB));

  // R9: no segment and no enabled hole means main memory
  p_unclaimed_dram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(|seg_hit) && !(hole_en && hole_hit)) |=> (out_route == RT_DRAM));

  // R10: result strobe trails request strobe by exactly one cycle
  p_strobe_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_strobe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_route != 2'd3));
endmodule

// File: rtl/legacy_region_router.sv
module legacy_region_router
  import lrr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic              req_io,
  output logic              out_valid,
  output logic [1:0]        out_route
);
  logic                        hole_en;
  logic [NSEG-1:0][ATTR_W-1:0] attr;
  logic [NSEG-1:0]             seg_hit;
  logic                        hole_hit;
  route_t                      route_q;
  src_t                        src;

  assign src = src_t'(req_io);

  lrr_cfg_regs #(.CFG_AW(8), .BASE_OFS(8'h58)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hole_en(hole_en), .attr(attr)
  );

  lrr_seg_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .addr(req_addr), .seg_hit(seg_hit), .hole_hit(hole_hit)
  );

  lrr_route_decide u_decide (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_src(src), .seg_hit(seg_hit), .hole_hit(hole_hit), .hole_en(hole_en),
    .attr(attr), .out_valid(out_valid), .out_route(route_q)
  );

  assign out_route = route_q;
endmodule

// File: tb/legacy_region_router_bench.sv
module legacy_region_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'h0;
  logic        req_wr = 1'b0;
  logic        req_io = 1'b0;
  logic        out_valid;
  logic [1:0]  out_route;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit       m_hole = 0;
  bit [1:0] m_attr [13];

  always #2 clk = ~clk;

  legacy_region_router u_legacy_region_router (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_wr(req_wr), .req_io(req_io),
    .out_valid(out_valid), .out_route(out_route)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h58) return {m_hole, 7'b0};
    if (a == 8'h59) return {2'b00, m_attr[12], 4'h0};
    if (a >= 8'h5A && a <= 8'h5F) begin
      int k = int'(a) - 'h5A;
      return {2'b00, m_attr[2*k+1], 2'b00, m_attr[2*k]};
    end
    return 8'h00;
  endfunction

  function automatic logic [1:0] exp_route(logic [31:0] a, bit wr, bit io);
    int idx;
    if (m_hole && a >= 32'hF0_0000 && a < 32'h100_0000) return io ? 2'd2 : 2'd1;
    if (a >= 32'hC_0000 && a < 32'h10_0000) begin
      idx = (a >= 32'hF_0000) ? 12 : int'((a - 32'hC_0000) >> 14);
      return (wr ? m_attr[idx][1] : m_attr[idx][0]) ? 2'd0 : 2'd1;
    end
    return 2'd0;
  endfunction

  task automatic cfg_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (a == 8'h58) m_hole = d[7];
    else if (a == 8'h59) m_attr[12] = d[5:4];
    else if (a >= 8'h5A && a <= 8'h5F) begin
      m_attr[2*(int'(a)-'h5A)]   = d[1:0];
      m_attr[2*(int'(a)-'h5A)+1] = d[5:4];
    end
  endtask

  task automatic cfg_check(string req, logic [7:0] a);
    cfg_addr = a;
    #1;
    chk(req, $sformatf("read %0h", a), cfg_rdata, exp_read(a));
  endtask

  task automatic request(string req, logic [31:0] a, bit wr, bit io);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wr = wr; req_io = io;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "out_valid after strobe", out_valid, 1);
    chk(req, $sformatf("route %0h wr%0d io%0d", a, wr, io), out_route, exp_route(a, wr, io));
  endtask

  function automatic logic [31:0] seg_addr(int s, logic [31:0] r);
    if (s == 12) return 32'hF_0000 + (r & 32'hFFFF);
    return 32'hC_0000 + 32'(s) * 32'h4000 + (r & 32'h3FFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "out_valid at reset", out_valid, 0);
    for (int a = 'h58; a <= 'h5F; a++) cfg_check("R1", 8'(a));
    request("R1", 32'h0000_1000, 0, 0);
    @(negedge clk);
    chk("R10", "out_valid idle", out_valid, 0);

    // R2, R3 reserved masking
    for (int a = 'h58; a <= 'h5F; a++) cfg_write(8'(a), 8'hFF);
    cfg_check("R2", 8'h58);
    cfg_check("R3", 8'h59);
    for (int a = 'h5A; a <= 'h5F; a++) cfg_check("R3", 8'(a));

    // R11 stray offsets
    cfg_write(8'h57, 8'h00);
    cfg_write(8'h60, 8'h00);
    cfg_write(8'hD8, 8'h00);
    for (int a = 'h58; a <= 'h5F; a++) cfg_check("R11", 8'(a));
    cfg_check("R11", 8'h57);
    cfg_check("R11", 8'h60);

    // R4, R5 every combination on every segment
    for (int c = 0; c < 4; c++) begin
      logic [7:0] d = {2'b00, 2'(c), 2'b00, 2'(c)};
      for (int a = 'h59; a <= 'h5F; a++) cfg_write(8'(a), d);
      for (int s = 0; s < 13; s++) begin
        request("R4", seg_addr(s, $urandom), 0, 0);
        request("R5", seg_addr(s, $urandom), 1, 1);
      end
    end
    // R4 distinct per-segment patterns catch mis-indexing
    for (int a = 'h59; a <= 'h5F; a++) cfg_write(8'(a), 8'($urandom));
    for (int s = 0; s < 13; s++) begin
      request("R4", seg_addr(s, 0), 0, 0);
      request("R5", seg_addr(s, 32'hFFFF), 1, 0);
    end

    // R9 unclaimed windows
    request("R9", 32'h000A_0000, 0, 0);
    request("R9", 32'h000B_FFFF, 1, 1);
    request("R9", 32'h0010_0000, 0, 0);
    request("R9", 32'h000B_FFFF + 32'h4_0001, 0, 1);

    // R8 hole off
    cfg_write(8'h58, 8'h00);
    request("R8", 32'h00F0_0000, 0, 0);
    request("R8", 32'h00FF_FFFF, 1, 1);
    // R6, R7 hole on, both edges
    cfg_write(8'h58, 8'h80);
    request("R6", 32'h00F0_0000, 0, 0);
    request("R6", 32'h00FF_FFFF, 1, 0);
    request("R7", 32'h00F0_0000, 1, 1);
    request("R7", 32'h00FF_FFFF, 0, 1);
    request("R8", 32'h00EF_FFFF, 0, 0);
    request("R8", 32'h0100_0000, 0, 1);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int kind = $urandom_range(0, 5);
      logic [31:0] r = $urandom;
      logic [31:0] a;
      if (($urandom & 7) == 0) begin
        int ra = $urandom_range('h56, 'h61);
        logic [7:0] rd = 8'($urandom);
        cfg_write(8'(ra), rd);
        cfg_check("R3", 8'(ra));
      end
      case (kind)
        0, 1: a = seg_addr($urandom_range(0, 12), r);
        2: a = 32'hA_0000 + (r & 32'h1_FFFF);
        3: a = 32'hF0_0000 + (r & 32'hF_FFFF);
        4: a = 32'hEF_FFF0 + (r & 32'h1F);
        default: a = r;
      endcase
      request("R4", a, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule